// File: doc/BRIEF.md
# TMDS Clock-Lane Pattern Generator

This block produces the 10-bit character stream that a TMDS serializer sends on the clock lane. The stream repeats four programmable pattern slots, one slot per character. With every slot set to 0x001F each character is five ones followed by five zeros, so the lane toggles at one tenth of the bit rate. For link rates above 340 MHz the slots are set to 0x0000, 0x0000, 0x03FF, 0x03FF, which stretches one clock period over four characters and gives one fortieth of the bit rate.

Software writes the slots through a small register port. Slot writes land in shadow copies, and the generator only switches to them on a load command. A separate start command then begins emission. A test-control register has one enable bit that selects real pattern output; while it is clear, or while the generator is not started, the lane carries the all-zero idle word. The word stream leaves on a valid/ready interface: `out_valid` is high at all times after reset, and a word counts as consumed on every cycle with `out_ready` high. While `out_ready` is low the word and the slot position are held.

Top module: `tmds_clkpat_gen`

## Requirements
- R1: After reset `out_valid` is 1 and `out_data` is 0, and it stays 0 until a load and a start have both happened with the enable bit set.
- R2: Writing a pattern register (address 0 holds slot 0 in bits 15:0 and slot 1 in bits 31:16; address 1 holds slot 2 in bits 15:0 and slot 3 in bits 31:16) changes only the shadow copy; the emitted words do not change.
- R3: Writing 1 to the command register (address 2) copies all shadow slots into the active set and stops emission; `out_data` is 0 from the next cycle until a start.
- R4: Writing 2 to the command register starts emission only if a load has happened since reset; without a prior load it is ignored, and when already running it has no effect on the sequence.
- R5: While running with the enable bit set, the word is the low 10 bits of the current active slot, starting at slot 0 and stepping 0, 1, 2, 3, then wrapping to 0 after each accepted word.
- R6: While `out_ready` is low the word and the slot position hold; the sequence resumes with the next slot once a word is accepted.
- R7: Bit 12 of the test-control register (address 3) enables pattern output; while it is 0 the word is 0, and when set again emission restarts from slot 0. Other bits of that register are ignored.
- R8: Command values other than 1 and 2 have no effect on the emitted sequence.
- R9: The reset contents of every slot are 0x001F, so a load with no slot writes gives the divide-by-10 word 0x01F on every character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0,1 pattern, 2 command, 3 test-control |
| wr_data | input | 32 | Register write data |
| out_ready | input | 1 | Serializer accepts the current word |
| out_valid | output | 1 | Word available (high after reset) |
| out_data | output | 10 | Clock-lane character |

## Verification
The functions that can meet in one cycle are the slot step taken on an accepted word and a register write that alters the generator's state: a load command, a shadow write or a start. The bench issues these writes while words are streaming with `out_ready` high, so the write edge is also a stepping edge, and it also starts the generator while `out_ready` is low. It judges the outcome by the next words: a shadow write must leave the old sequence running one step further, a load must give a zero word, and a start must present slot 0 and hold it under back-pressure.

// File: rtl/tmds_clkpat_pkg.sv
`timescale 1ns/1ps
package tmds_clkpat_pkg;
  typedef enum logic [1:0] {
    PG_EMPTY = 2'd0,
    PG_ARMED = 2'd1,
    PG_RUN   = 2'd2
  } pg_state_e;

  localparam int unsigned OP_LOAD  = 1;
  localparam int unsigned OP_START = 2;
endpackage

// File: rtl/tmds_clkpat_regs.sv
`timescale 1ns/1ps
module tmds_clkpat_regs #(
  parameter int REG_W        = 32,
  parameter int SLOT_W       = 16,
  parameter int WORD_W       = 10,
  parameter int NUM_SLOTS    = 4,
  parameter int TEST_BIT     = 12,
  parameter int ADDR_W       = 2,
  parameter logic [WORD_W-1:0] DEFAULT_WORD = 10'h01F
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [REG_W-1:0]                 wr_data,
  output logic [NUM_SLOTS-1:0][WORD_W-1:0] shadow_slots,
  output logic                             load_cmd,
  output logic                             start_cmd,
  output logic                             test_en
);
  import tmds_clkpat_pkg::*;

  localparam int SLOTS_PER_REG = REG_W / SLOT_W;
  localparam int NREGS         = NUM_SLOTS / SLOTS_PER_REG;
  localparam int CMD_ADDR      = NREGS;
  localparam int TEST_ADDR     = NREGS + 1;

  logic cmd_hit;
  logic test_hit;

  assign cmd_hit   = wr_en && (wr_addr == ADDR_W'(CMD_ADDR));
  assign test_hit  = wr_en && (wr_addr == ADDR_W'(TEST_ADDR));
  assign load_cmd  = cmd_hit && (wr_data == REG_W'(OP_LOAD));
  assign start_cmd = cmd_hit && (wr_data == REG_W'(OP_START));

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam int REG_IDX = s / SLOTS_PER_REG;
    localparam int LANE    = s % SLOTS_PER_REG;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_slots[s] <= DEFAULT_WORD;
      end else if (wr_en && (wr_addr == ADDR_W'(REG_IDX))) begin
        shadow_slots[s] <= wr_data[LANE*SLOT_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      test_en <= 1'b0;
    end else if (test_hit) begin
      test_en <= wr_data[TEST_BIT];
    end
  end
endmodule

// File: rtl/tmds_clkpat_bank.sv
`timescale 1ns/1ps
module tmds_clkpat_bank #(
  parameter int WORD_W    = 10,
  parameter int NUM_SLOTS = 4,
  parameter logic [WORD_W-1:0] DEFAULT_WORD = 10'h01F
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             load_cmd,
  input  logic                             start_cmd,
  input  logic [NUM_SLOTS-1:0][WORD_W-1:0] shadow_slots,
  output logic [NUM_SLOTS-1:0][WORD_W-1:0] act_slots,
  output logic                             running
);
  import tmds_clkpat_pkg::*;

  pg_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PG_EMPTY;
    end else if (load_cmd) begin
      state_q <= PG_ARMED;
    end else if (start_cmd && (state_q != PG_EMPTY)) begin
      state_q <= PG_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        act_slots[s] <= DEFAULT_WORD;
      end
    end else if (load_cmd) begin
      act_slots <= shadow_slots;
    end
  end

  assign running = (state_q == PG_RUN);
endmodule

// File: rtl/tmds_clkpat_seq.sv
`timescale 1ns/1ps
module tmds_clkpat_seq #(
  parameter int WORD_W    = 10,
  parameter int NUM_SLOTS = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_SLOTS-1:0][WORD_W-1:0] act_slots,
  input  logic                             running,
  input  logic                             test_en,
  input  logic                             out_ready,
  output logic                             out_valid,
  output logic [WORD_W-1:0]                out_data
);
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);

  logic             emit;
  logic [IDX_W-1:0] idx_q;
  logic             valid_q;

  assign emit = running && test_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (!emit) begin
      idx_q <= '0;
    end else if (valid_q && out_ready) begin
      idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = emit ? act_slots[idx_q] : '0;
endmodule

// File: rtl/tmds_clkpat_gen.sv
`timescale 1ns/1ps
module tmds_clkpat_gen #(
  parameter int REG_W     = 32,
  parameter int SLOT_W    = 16,
  parameter int WORD_W    = 10,
  parameter int NUM_SLOTS = 4,
  parameter int TEST_BIT  = 12,
  parameter logic [WORD_W-1:0] DEFAULT_WORD = 10'h01F,
  localparam int NREGS  = NUM_SLOTS * SLOT_W / REG_W,
  localparam int ADDR_W = $clog2(NREGS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data
);
  logic [NUM_SLOTS-1:0][WORD_W-1:0] shadow_slots;
  logic [NUM_SLOTS-1:0][WORD_W-1:0] act_slots;
  logic load_cmd;
  logic start_cmd;
  logic test_en;
  logic running;

  tmds_clkpat_regs #(
    .REG_W(REG_W), .SLOT_W(SLOT_W), .WORD_W(WORD_W), .NUM_SLOTS(NUM_SLOTS),
    .TEST_BIT(TEST_BIT), .ADDR_W(ADDR_W), .DEFAULT_WORD(DEFAULT_WORD)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .shadow_slots(shadow_slots), .load_cmd(load_cmd),
    .start_cmd(start_cmd), .test_en(test_en)
  );

  tmds_clkpat_bank #(
    .WORD_W(WORD_W), .NUM_SLOTS(NUM_SLOTS), .DEFAULT_WORD(DEFAULT_WORD)
  ) bank_i (
    .clk(clk), .rst_n(rst_n), .load_cmd(load_cmd), .start_cmd(start_cmd),
    .shadow_slots(shadow_slots), .act_slots(act_slots), .running(running)
  );

  tmds_clkpat_seq #(
    .WORD_W(WORD_W), .NUM_SLOTS(NUM_SLOTS)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .act_slots(act_slots), .running(running),
    .test_en(test_en), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data)
  );
endmodule

// File: rtl/tmds_clkpat_chk.sv
`timescale 1ns/1ps
module tmds_clkpat_chk #(
  parameter int REG_W    = 32,
  parameter int WORD_W   = 10,
  parameter int TEST_BIT = 12,
  parameter int NREGS    = 2,
  parameter int ADDR_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [REG_W-1:0]  wr_data,
  input logic              out_ready,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_data
);
  logic cmd_wr;
  logic test_wr;
  logic pat_wr;

  assign cmd_wr  = wr_en && (wr_addr == ADDR_W'(NREGS));
  assign test_wr = wr_en && (wr_addr == ADDR_W'(NREGS + 1));
  assign pat_wr  = wr_en && (wr_addr < ADDR_W'(NREGS));

  a_r1_valid_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(out_valid));

  a_r2_shadow_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_wr && !out_ready) |=> $stable(out_data));

  a_r3_load_idles: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wr_data == REG_W'(1)) |=> (out_data == '0));

  a_r6_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !wr_en) |=> $stable(out_data));

  a_r7_disable_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (test_wr && !wr_data[TEST_BIT]) |=> (out_data == '0));

  a_r8_bad_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wr_data != REG_W'(1) && wr_data != REG_W'(2) && !out_ready)
      |=> $stable(out_data));
endmodule

bind tmds_clkpat_gen tmds_clkpat_chk #(
  .REG_W(REG_W), .WORD_W(WORD_W), .TEST_BIT(TEST_BIT),
  .NREGS(NREGS), .ADDR_W(ADDR_W)
) chk_i (.*);

// File: tb/tmds_clkpat_gen_tb.sv
`timescale 1ns/1ps
module tmds_clkpat_gen_tb_top;
  localparam logic [1:0] A_PAT0 = 2'd0;
  localparam logic [1:0] A_PAT1 = 2'd1;
  localparam logic [1:0] A_CMD  = 2'd2;
  localparam logic [1:0] A_TEST = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic        out_ready;
  logic        out_valid;
  logic [9:0]  out_data;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  logic [15:0] exp_pat [4];

  always #5 clk = ~clk;

  tmds_clkpat_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data)
  );

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // called at a falling edge; exactly one rising edge carries the write
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_exp(input logic [31:0] r0, input logic [31:0] r1);
    exp_pat[0] = r0[15:0];  exp_pat[1] = r0[31:16];
    exp_pat[2] = r1[15:0];  exp_pat[3] = r1[31:16];
  endtask

  task automatic expect_run(input string tag, input int start, input int n);
    for (int i = 0; i < n; i++) begin
      chk(tag, out_data, exp_pat[(start + i) % 4][9:0]);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid", {9'd0, out_valid}, 10'd1);
    chk("R1 idle", out_data, 10'd0);
  endtask

  task automatic t_start_without_load;
    wr(A_TEST, 32'h0000_1000);
    wr(A_CMD, 32'd2);
    chk("R4 no load", out_data, 10'd0);
    @(negedge clk);
    chk("R4 no load", out_data, 10'd0);
  endtask

  task automatic t_default_pattern;
    wr(A_CMD, 32'd1);
    chk("R3 armed", out_data, 10'd0);
    set_exp(32'h001F_001F, 32'h001F_001F);
    wr(A_CMD, 32'd2);
    expect_run("R9 div10", 0, 8);
  endtask

  task automatic t_fast_pattern;
    wr(A_PAT0, 32'h0000_0000);
    chk("R2 shadow", out_data, 10'h01F);
    wr(A_PAT1, 32'h03FF_03FF);
    chk("R2 shadow", out_data, 10'h01F);
    wr(A_CMD, 32'd1);
    chk("R3 load", out_data, 10'd0);
    @(negedge clk);
    chk("R3 load", out_data, 10'd0);
    set_exp(32'h0000_0000, 32'h03FF_03FF);
    wr(A_CMD, 32'd2);
    expect_run("R5 div40", 0, 8);
  endtask

  task automatic t_slot_order;
    wr(A_PAT0, 32'h0222_0111);
    wr(A_PAT1, 32'hF333_F044);
    wr(A_CMD, 32'd1);
    set_exp(32'h0222_0111, 32'hF333_F044);
    wr(A_CMD, 32'd2);
    expect_run("R5 order", 0, 6);
  endtask

  task automatic t_backpressure;
    // current word is slot 2
    out_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R6 hold", out_data, exp_pat[2][9:0]);
    end
    out_ready = 1'b1;
    chk("R6 hold", out_data, exp_pat[2][9:0]);
    @(negedge clk);
    expect_run("R6 resume", 3, 3);
  endtask

  task automatic t_test_bit;
    wr(A_TEST, 32'hFFFF_EFFF);
    chk("R7 off", out_data, 10'd0);
    @(negedge clk);
    chk("R7 off", out_data, 10'd0);
    wr(A_TEST, 32'h0000_1000);
    expect_run("R7 restart", 0, 4);
  endtask

  task automatic t_bad_cmd;
    // current word is slot 0
    wr(A_CMD, 32'd3);
    chk("R8 cmd3", out_data, exp_pat[1][9:0]);
    wr(A_CMD, 32'd0);
    chk("R8 cmd0", out_data, exp_pat[2][9:0]);
    wr(A_CMD, 32'd2);
    chk("R4 restart no effect", out_data, exp_pat[3][9:0]);
  endtask

  task automatic t_collision;
    // slot step and shadow write share an edge
    wr(A_PAT0, 32'h00AA_0055);
    chk("R2 step with write", out_data, exp_pat[0][9:0]);
    wr(A_CMD, 32'd1);
    chk("R3 load with step", out_data, 10'd0);
    set_exp(32'h00AA_0055, 32'hF333_F044);
    out_ready = 1'b0;
    wr(A_CMD, 32'd2);
    chk("R6 start under stall", out_data, exp_pat[0][9:0]);
    @(negedge clk);
    chk("R6 start under stall", out_data, exp_pat[0][9:0]);
    out_ready = 1'b1;
    @(negedge clk);
    expect_run("R5 new set", 1, 4);
  endtask

  initial begin
    t_reset();
    t_start_without_load();
    t_default_pattern();
    t_fast_pattern();
    t_slot_order();
    t_backpressure();
    t_test_bit();
    t_bad_cmd();
    t_collision();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule